// File: doc/BRIEF.md
# ECC Partial-Write Merge Unit

This unit sits between a byte-granular request port and a memory channel that moves data in 16-byte slots, two 64-bit words per slot. Each word carries an 8-bit single-error-correct, double-error-detect check byte. A read costs one slot. Its data is checked and corrected on the way back. A write whose byte enables leave every word either wholly covered or wholly untouched also costs one slot. The check bytes for that write are computed on the fly.

A write that covers only part of some word cannot produce a valid check byte from the request alone. When protection is switched on, such a write becomes a read-modify-write taking two slots. The unit reads the slot and corrects any single-bit error. It then merges the requested bytes over the corrected data, recomputes the check bytes and writes the touched words back. If a double-bit error turns up during the read phase, the write is dropped and the response carries an error flag. When protection is off, every write takes one slot and the request's byte enables go to the channel unchanged.

The controller is a six-state machine:
- ST_IDLE accepts a request. It moves to ST_WRITE for a write that needs no merge, and to ST_READ otherwise.
- ST_WRITE issues the write and moves to ST_DONE.
- ST_READ issues the read and moves to ST_WAIT.
- ST_WAIT holds until read data returns. For a read-modify-write with no uncorrectable word it moves to ST_MERGE. In every other case it moves to ST_DONE.
- ST_MERGE issues the write-back and moves to ST_DONE.
- ST_DONE presents the response for one cycle and returns to ST_IDLE.

Each response reports how many slots its request used. A running counter totals every slot command issued.

Top module: `ecc_rmw_top`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, mem_valid is 0 and slot_count is 0.
- R2: A read takes exactly one slot command (mem_write=0). Its response has rsp_slots=1, and with protection on, rsp_rdata is the stored data with any single-bit error corrected.
- R3: With protection on, a write whose byte enables cover each 8-byte word either fully or not at all issues one write and no read (rsp_slots=1). mem_be is 8'hFF for each word with any enable set and 8'h00 for the others. Words that are not written keep their stored contents.
- R4: With protection on, a write that enables some but not all bytes of any word issues one read and then one write (rsp_slots=2). In each touched word, the written data takes the enabled bytes from the request and the other bytes from the corrected read data.
- R5: With protection off, every write issues exactly one write command and no read, and mem_be equals req_be. The check bytes written in this mode are not specified.
- R6: Word w of a slot occupies bits 64w+63:64w of the data and bits 8w+7:8w of the check byte vector. The data bits are numbered 0..63 and placed in order at Hamming positions 1..71, skipping 1, 2, 4, 8, 16, 32 and 64. Check bit j (j=0..6) is the XOR of the data bits whose position has bit j set. Check bit 7 is the XOR of all 64 data bits and check bits 0..6. Every written word carries check bits computed this way.
- R7: With protection on, a single flipped data bit or check bit in a word is corrected on read (rsp_err=0) and before a merge. The write-back carries the corrected data and fresh check bits.
- R8: With protection on, a word whose check reports two flipped bits gives rsp_err=1 on a read. On a read-modify-write it causes the write to be dropped: no write command, memory unchanged, rsp_err=1, rsp_slots=1.
- R9: req_ready is 0 from the cycle after a request is accepted until the response has been given, so no request is taken while a slot command or write-back is still pending.
- R10: slot_count increments by one for every slot command (read or write) issued on the memory side.
- R11: With protection off, a read returns the raw stored data without correction and rsp_err=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ecc_en | input | 1 | Protection enable, sampled when a request is accepted |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (8) | Slot address |
| req_be | input | SLOT_BYTES (16) | Byte enables for a write |
| req_wdata | input | 8*SLOT_BYTES (128) | Write data |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_rdata | output | 8*SLOT_BYTES (128) | Read data |
| rsp_err | output | 1 | Uncorrectable error seen |
| rsp_slots | output | 2 | Slot commands used by the request |
| mem_valid | output | 1 | Slot command issued this cycle |
| mem_write | output | 1 | 1 = slot write, 0 = slot read |
| mem_addr | output | ADDR_W (8) | Slot address |
| mem_be | output | SLOT_BYTES (16) | Byte write enables |
| mem_wdata | output | 8*SLOT_BYTES (128) | Write data |
| mem_wcheck | output | SLOT_BYTES (16) | Check bytes, one per word |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 8*SLOT_BYTES (128) | Returned data |
| mem_rcheck | input | SLOT_BYTES (16) | Returned check bytes |
| slot_count | output | CNT_W (16) | Running total of slot commands |

## Verification
The hardest case to reach from the ports is a read-modify-write whose read phase meets a damaged word: a correctable error must be repaired inside the merge, and an uncorrectable one must suppress the write-back. The bench memory model can flip chosen stored data or check bits between requests. The bench first corrupts a slot this way and then sends a one-byte write to it. It then checks the write command count, the stored word and its check byte against the clean value it kept before the damage.

// File: rtl/ecc_rmw_pkg.sv
package ecc_rmw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_READ,
        ST_WAIT,
        ST_MERGE,
        ST_DONE
    } rmw_state_t;

    // XOR of the Hamming positions of all set data bits (positions 1..71, powers of two skipped)
    function automatic logic [6:0] ecc_syn(input logic [63:0] d);
        logic [6:0] s;
        logic [6:0] k;
        s = '0;
        k = '0;
        for (int p = 1; p < 72; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (d[k[5:0]]) s = s ^ 7'(p);
                k = k + 7'd1;
            end
        end
        return s;
    endfunction

    function automatic logic [7:0] ecc_check(input logic [63:0] d);
        logic [6:0] s;
        s = ecc_syn(d);
        return {(^d) ^ (^s), s};
    endfunction

endpackage

// File: rtl/ecc_rmw_enc.sv
module ecc_rmw_enc
    import ecc_rmw_pkg::*;
(
    input  logic [63:0] data,
    output logic [7:0]  check
);
    assign check = ecc_check(data);
endmodule

// File: rtl/ecc_rmw_dec.sv
module ecc_rmw_dec
    import ecc_rmw_pkg::*;
(
    input  logic [63:0] data,
    input  logic [7:0]  check,
    output logic [63:0] fixed,
    output logic        dbl
);
    logic [6:0] syn;
    logic       ovr;
    logic [6:0] k;

    always_comb begin
        syn   = ecc_syn(data) ^ check[6:0];
        ovr   = (^data) ^ (^check);
        fixed = data;
        dbl   = 1'b0;
        k     = '0;
        if (syn != '0) begin
            if (!ovr || syn > 7'd71) begin
                dbl = 1'b1;
            end else begin
                for (int p = 1; p < 72; p++) begin
                    if ((p & (p - 1)) != 0) begin
                        if (7'(p) == syn) fixed[k[5:0]] = ~data[k[5:0]];
                        k = k + 7'd1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/ecc_rmw_top.sv
module ecc_rmw_top
    import ecc_rmw_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int SLOT_BYTES = 16,
    parameter int CNT_W      = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ecc_en,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic                    req_write,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [SLOT_BYTES-1:0]   req_be,
    input  logic [8*SLOT_BYTES-1:0] req_wdata,
    output logic                    rsp_valid,
    output logic [8*SLOT_BYTES-1:0] rsp_rdata,
    output logic                    rsp_err,
    output logic [1:0]              rsp_slots,
    output logic                    mem_valid,
    output logic                    mem_write,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [SLOT_BYTES-1:0]   mem_be,
    output logic [8*SLOT_BYTES-1:0] mem_wdata,
    output logic [SLOT_BYTES-1:0]   mem_wcheck,
    input  logic                    mem_rvalid,
    input  logic [8*SLOT_BYTES-1:0] mem_rdata,
    input  logic [SLOT_BYTES-1:0]   mem_rcheck,
    output logic [CNT_W-1:0]        slot_count
);
    localparam int WORDS  = SLOT_BYTES / 8;
    localparam int DATA_W = 8 * SLOT_BYTES;

    rmw_state_t state_q, state_d;

    logic                  wr_q, ecc_q, rmw_q, err_q;
    logic [ADDR_W-1:0]     addr_q;
    logic [SLOT_BYTES-1:0] be_q;
    logic [DATA_W-1:0]     wdata_q, rd_q, merged;
    logic [1:0]            slots_q;
    logic [CNT_W-1:0]      cnt_q;

    logic [DATA_W-1:0]     dec_data;
    logic [WORDS-1:0]      dec_dbl;
    logic [SLOT_BYTES-1:0] enc_chk;
    logic [SLOT_BYTES-1:0] be_exp;
    logic [WORDS-1:0]      req_part;
    logic                  need_rmw;
    logic                  accept;
    logic                  rd_bad;

    // per-word check logic and enable expansion
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        ecc_rmw_dec dec_i (
            .data  (mem_rdata[64*w +: 64]),
            .check (mem_rcheck[8*w +: 8]),
            .fixed (dec_data[64*w +: 64]),
            .dbl   (dec_dbl[w])
        );
        ecc_rmw_enc enc_i (
            .data  (merged[64*w +: 64]),
            .check (enc_chk[8*w +: 8])
        );
        assign be_exp[8*w +: 8] = {8{|be_q[8*w +: 8]}};
        assign req_part[w]      = (|req_be[8*w +: 8]) && !(&req_be[8*w +: 8]);
    end

    // byte merge: request bytes over corrected read bytes
    for (genvar b = 0; b < SLOT_BYTES; b++) begin : g_byte
        assign merged[8*b +: 8] = be_q[b] ? wdata_q[8*b +: 8] : rd_q[8*b +: 8];
    end

    assign accept   = (state_q == ST_IDLE) && req_valid;
    assign need_rmw = ecc_en && req_write && (|req_part);
    assign rd_bad   = ecc_q && (|dec_dbl);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = (req_write && !need_rmw) ? ST_WRITE : ST_READ;
            ST_WRITE: state_d = ST_DONE;
            ST_READ:  state_d = ST_WAIT;
            ST_WAIT:  if (mem_rvalid) state_d = (rmw_q && !rd_bad) ? ST_MERGE : ST_DONE;
            ST_MERGE: state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        mem_valid  = (state_q == ST_WRITE) || (state_q == ST_READ) || (state_q == ST_MERGE);
        mem_write  = (state_q == ST_WRITE) || (state_q == ST_MERGE);
        mem_addr   = addr_q;
        mem_be     = ecc_q ? be_exp : be_q;
        mem_wdata  = merged;
        mem_wcheck = enc_chk;
        rsp_valid  = (state_q == ST_DONE);
        rsp_rdata  = rd_q;
        rsp_err    = err_q;
        rsp_slots  = slots_q;
        slot_count = cnt_q;
    end

    // request capture, read capture and slot accounting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            ecc_q   <= 1'b0;
            rmw_q   <= 1'b0;
            err_q   <= 1'b0;
            addr_q  <= '0;
            be_q    <= '0;
            wdata_q <= '0;
            rd_q    <= '0;
            slots_q <= '0;
            cnt_q   <= '0;
        end else begin
            if (accept) begin
                wr_q    <= req_write;
                ecc_q   <= ecc_en;
                rmw_q   <= need_rmw;
                err_q   <= 1'b0;
                addr_q  <= req_addr;
                be_q    <= req_be;
                wdata_q <= req_wdata;
                slots_q <= '0;
            end
            if (state_q == ST_WAIT && mem_rvalid) begin
                rd_q  <= ecc_q ? dec_data : mem_rdata;
                err_q <= rd_bad;
            end
            if (mem_valid) begin
                slots_q <= slots_q + 2'd1;
                cnt_q   <= cnt_q + CNT_W'(1);
            end
        end
    end

    AST_BUSY_WHILE_ISSUING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> !req_ready);                                           // R9
    AST_RMW_TWO_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rmw_q && !rsp_err) |-> (rsp_slots == 2'd2));           // R4
    AST_PLAIN_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rmw_q) |-> (rsp_slots == 2'd1));                      // R2
    AST_ABORT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> !$past(mem_valid && mem_write));          // R8
    AST_WB_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_write && rmw_q) |-> $past(mem_rvalid));            // R4
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |=> (slot_count == $past(slot_count) + CNT_W'(1)));        // R10
    AST_PLAIN_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_write) |-> !(wr_q && !ecc_q));                    // R5
endmodule

// File: tb/ecc_rmw_top_tb_top.sv
`timescale 1ns/1ps
module ecc_rmw_top_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ecc_en = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic         req_write = 1'b0;
    logic [7:0]   req_addr = '0;
    logic [15:0]  req_be = '0;
    logic [127:0] req_wdata = '0;
    logic         rsp_valid;
    logic [127:0] rsp_rdata;
    logic         rsp_err;
    logic [1:0]   rsp_slots;
    logic         mem_valid, mem_write;
    logic [7:0]   mem_addr;
    logic [15:0]  mem_be;
    logic [127:0] mem_wdata;
    logic [15:0]  mem_wcheck;
    logic         mem_rvalid;
    logic [127:0] mem_rdata;
    logic [15:0]  mem_rcheck;
    logic [15:0]  slot_count;

    always #2 clk = ~clk;

    ecc_rmw_top dut_i (
        .clk(clk), .rst_n(rst_n), .ecc_en(ecc_en),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .rsp_slots(rsp_slots),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_wcheck(mem_wcheck), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .mem_rcheck(mem_rcheck), .slot_count(slot_count)
    );

    int n_chk = 0;
    int n_bad = 0;

    // bench-side check byte: walk positions 1..71, skip powers of two
    function automatic logic [7:0] tb_chk64(input logic [63:0] d);
        logic [7:0] c;
        int idx;
        c = '0;
        idx = 0;
        for (int pos = 1; pos <= 71; pos++) begin
            if (pos != 1 && pos != 2 && pos != 4 && pos != 8 &&
                pos != 16 && pos != 32 && pos != 64) begin
                if (d[idx]) begin
                    for (int j = 0; j < 7; j++) if (((pos >> j) & 1) == 1) c[j] = ~c[j];
                end
                idx++;
            end
        end
        c[7] = (^d) ^ (^c[6:0]);
        return c;
    endfunction

    function automatic logic [15:0] tb_chk(input logic [127:0] d);
        return {tb_chk64(d[127:64]), tb_chk64(d[63:0])};
    endfunction

    function automatic logic [127:0] tb_merge(input logic [127:0] old, input logic [127:0] nw,
                                              input logic [15:0] be);
        logic [127:0] r;
        r = old;
        for (int b = 0; b < 16; b++) if (be[b]) r[8*b +: 8] = nw[8*b +: 8];
        return r;
    endfunction

    // memory model with bit-flip injection
    logic [127:0] mdat [256];
    logic [15:0]  mchk [256];
    int           rd_cnt, wr_cnt;
    logic [15:0]  last_be;
    logic         poke = 1'b0;
    logic [7:0]   poke_addr = '0;
    logic [127:0] poke_d = '0;
    logic [15:0]  poke_c = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_rvalid <= 1'b0;
            mem_rdata  <= '0;
            mem_rcheck <= '0;
            rd_cnt     <= 0;
            wr_cnt     <= 0;
            last_be    <= '0;
            for (int i = 0; i < 256; i++) begin
                mdat[i] <= {16{8'(i)}} ^ 128'h0123456789ABCDEF_FEDCBA9876543210;
                mchk[i] <= tb_chk({16{8'(i)}} ^ 128'h0123456789ABCDEF_FEDCBA9876543210);
            end
        end else begin
            mem_rvalid <= 1'b0;
            if (poke) begin
                mdat[poke_addr] <= mdat[poke_addr] ^ poke_d;
                mchk[poke_addr] <= mchk[poke_addr] ^ poke_c;
            end
            if (mem_valid) begin
                if (mem_write) begin
                    for (int b = 0; b < 16; b++)
                        if (mem_be[b]) mdat[mem_addr][8*b +: 8] <= mem_wdata[8*b +: 8];
                    for (int w = 0; w < 2; w++)
                        if (|mem_be[8*w +: 8]) mchk[mem_addr][8*w +: 8] <= mem_wcheck[8*w +: 8];
                    wr_cnt  <= wr_cnt + 1;
                    last_be <= mem_be;
                end else begin
                    mem_rvalid <= 1'b1;
                    mem_rdata  <= mdat[mem_addr];
                    mem_rcheck <= mchk[mem_addr];
                    rd_cnt     <= rd_cnt + 1;
                end
            end
        end
    end

    task automatic check(input bit ok, input string rq, input logic [127:0] act,
                         input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", rq, act, exp);
        end
    endtask

    task automatic inject(input logic [7:0] a, input logic [127:0] dm, input logic [15:0] cm);
        @(negedge clk);
        poke = 1'b1; poke_addr = a; poke_d = dm; poke_c = cm;
        @(negedge clk);
        poke = 1'b0;
    endtask

    logic [127:0] r_data;
    logic         r_err;
    logic [1:0]   r_slots;
    int           d_rd, d_wr;

    task automatic do_req(input bit wr, input logic [7:0] a, input logic [15:0] be,
                          input logic [127:0] wd);
        int rd0, wr0, waited;
        rd0 = rd_cnt; wr0 = wr_cnt;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R9 busy after accept", 128'(req_ready), 128'd0);
        waited = 0;
        while (!rsp_valid && waited < 50) begin
            @(negedge clk);
            waited++;
        end
        check(rsp_valid == 1'b1, "R9 response arrives", 128'(rsp_valid), 128'd1);
        r_data = rsp_rdata; r_err = rsp_err; r_slots = rsp_slots;
        @(negedge clk);
        d_rd = rd_cnt - rd0; d_wr = wr_cnt - wr0;
    endtask

    task automatic t_reset();
        check(req_ready == 1'b1 && rsp_valid == 1'b0, "R1 ready/rsp", {rsp_valid, req_ready}, 128'd1);
        check(mem_valid == 1'b0 && slot_count == '0, "R1 idle memory side",
              {mem_valid, slot_count}, 128'd0);
    endtask

    task automatic t_full_write();
        logic [127:0] wd;
        wd = 128'hDEADBEEF_0BADF00D_CAFEBABE_12345678;
        ecc_en = 1'b1;
        do_req(1'b1, 8'd3, 16'hFFFF, wd);
        check(r_slots == 2'd1 && d_rd == 0 && d_wr == 1, "R3 full write one slot",
              {r_slots, 8'(d_rd), 8'(d_wr)}, {2'd1, 8'd0, 8'd1});
        check(mdat[3] == wd, "R3 stored data", mdat[3], wd);
        check(mchk[3] == tb_chk(wd), "R6 check bytes", 128'(mchk[3]), 128'(tb_chk(wd)));
        check(last_be == 16'hFFFF, "R3 mem_be", 128'(last_be), 128'hFFFF);
    endtask

    task automatic t_read();
        do_req(1'b0, 8'd3, 16'h0000, '0);
        check(r_data == mdat[3] && r_err == 1'b0, "R2 read data", r_data, mdat[3]);
        check(r_slots == 2'd1 && d_rd == 1 && d_wr == 0, "R2 read one slot",
              {r_slots, 8'(d_rd), 8'(d_wr)}, {2'd1, 8'd1, 8'd0});
    endtask

    task automatic t_partial_write();
        logic [127:0] old, exp, wd;
        old = mdat[3];
        wd  = {16{8'h5A}};
        do_req(1'b1, 8'd3, 16'h0001, wd);
        exp = tb_merge(old, wd, 16'h0001);
        check(r_slots == 2'd2 && d_rd == 1 && d_wr == 1, "R4 rmw two slots",
              {r_slots, 8'(d_rd), 8'(d_wr)}, {2'd2, 8'd1, 8'd1});
        check(mdat[3] == exp, "R4 merged data", mdat[3], exp);
        check(mchk[3] == tb_chk(exp), "R6 merged check", 128'(mchk[3]), 128'(tb_chk(exp)));
    endtask

    task automatic t_upper_word_only();
        logic [127:0] old, exp, wd;
        old = mdat[4];
        wd  = {2{64'h1122334455667788}};
        do_req(1'b1, 8'd4, 16'hFF00, wd);
        exp = tb_merge(old, wd, 16'hFF00);
        check(r_slots == 2'd1 && d_rd == 0, "R3 whole-word write no read",
              {r_slots, 8'(d_rd)}, {2'd1, 8'd0});
        check(mdat[4] == exp && last_be == 16'hFF00, "R3 untouched word kept", mdat[4], exp);
    endtask

    task automatic t_single_error();
        logic [127:0] clean, exp, wd;
        clean = mdat[3];
        inject(8'd3, 128'd1 << 37, 16'h0000);
        do_req(1'b0, 8'd3, 16'h0000, '0);
        check(r_data == clean && r_err == 1'b0, "R7 corrected read", r_data, clean);
        wd = {16{8'hC3}};
        do_req(1'b1, 8'd3, 16'h0004, wd);
        exp = tb_merge(clean, wd, 16'h0004);
        check(mdat[3] == exp && r_slots == 2'd2, "R7 corrected merge", mdat[3], exp);
        check(mchk[3] == tb_chk(exp), "R7 fresh check bits", 128'(mchk[3]), 128'(tb_chk(exp)));
        clean = mdat[9];
        inject(8'd9, '0, 16'h0008);
        do_req(1'b0, 8'd9, 16'h0000, '0);
        check(r_data == clean && r_err == 1'b0, "R7 check-bit error", r_data, clean);
    endtask

    task automatic t_double_error();
        logic [127:0] bad;
        inject(8'd7, (128'd1 << 70) | (128'd1 << 75), 16'h0000);
        bad = mdat[7];
        do_req(1'b0, 8'd7, 16'h0000, '0);
        check(r_err == 1'b1, "R8 read flags error", 128'(r_err), 128'd1);
        do_req(1'b1, 8'd7, 16'h0100, {16{8'hEE}});
        check(r_err == 1'b1 && r_slots == 2'd1 && d_wr == 0, "R8 rmw aborted",
              {r_err, r_slots, 8'(d_wr)}, {1'b1, 2'd1, 8'd0});
        check(mdat[7] == bad, "R8 memory unchanged", mdat[7], bad);
    endtask

    task automatic t_ecc_off();
        logic [127:0] old, exp, wd, raw;
        ecc_en = 1'b0;
        old = mdat[5];
        wd  = {16{8'h99}};
        do_req(1'b1, 8'd5, 16'h00F0, wd);
        exp = tb_merge(old, wd, 16'h00F0);
        check(r_slots == 2'd1 && d_rd == 0 && d_wr == 1, "R5 single slot write",
              {r_slots, 8'(d_rd), 8'(d_wr)}, {2'd1, 8'd0, 8'd1});
        check(last_be == 16'h00F0, "R5 byte enables passed", 128'(last_be), 128'h00F0);
        check(mdat[5] == exp, "R5 stored bytes", mdat[5], exp);
        inject(8'd11, 128'd1 << 5, 16'h0000);
        raw = mdat[11];
        do_req(1'b0, 8'd11, 16'h0000, '0);
        check(r_data == raw && r_err == 1'b0, "R11 raw read", r_data, raw);
        ecc_en = 1'b1;
    endtask

    task automatic t_counter();
        check(slot_count == 16'(rd_cnt + wr_cnt), "R10 slot count total",
              128'(slot_count), 128'(rd_cnt + wr_cnt));
    endtask

    bit done = 1'b0;

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full_write();
        t_read();
        t_partial_write();
        t_upper_word_only();
        t_single_error();
        t_double_error();
        t_ecc_off();
        t_counter();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule